// File: doc/BRIEF.md
# Transceiver Direction Reset Sequencer

This block brings one direction of a serial transceiver (transmit or receive) out of reset in a fixed order. A full bring-up first pulses the clock-source PLL reset, then releases the internal oscillator reset once the PLL reports lock, then holds the PMA reset for a set number of cycles once both the PLL and the oscillator report lock, and finally releases the PCS reset when the user logic signals that it is ready. A done flag rises once the PCS is out of reset. Two instances, one per direction, run independently and may run at the same time.

A single asynchronous request input starts every run. While it is High the sequencer sits in its hold state. It is brought into the local clock through a two-flop synchronizer, and its falling edge launches the run. A mode input picks either a full bring-up or a component reset. A component reset leaves the PLL and oscillator alone and applies the PMA and PCS resets only to the sub-blocks whose select bits are High. Each wait for lock has a timeout. When it expires, the run restarts at the PLL pulse.

Top module: `xcvr_rst_seq`

## Requirements
- R1: A High on `rst_req`, however short, forces the hold state at once, with no clock edge needed. The run leaves hold on the third rising clock edge after `rst_req` returns Low: two synchronizer stages plus one edge-detect stage.
- R2: In full mode (`seq_mode`=1) the run begins with `pll_rst` High for PULSE_CYC cycles and `ilo_rst` High. `pll_rst` then falls, and `ilo_rst` falls on the edge after `pll_lock` is sampled High.
- R3: The PMA hold of PMA_CYC cycles starts only on the edge after `pll_lock` and `ilo_lock` are both sampled High. `pma_rst` stays asserted until that hold ends.
- R4: After the PMA hold, `pcs_rst` stays asserted until `user_rdy` is sampled High. It falls on the next edge, together with the rise of `rst_done`.
- R5: If a lock wait sees no lock for LOCK_TMO consecutive cycles, the run returns to the PLL pulse and `pll_rst` and `ilo_rst` go High again.
- R6: In component mode (`seq_mode`=0), `pll_rst` and `ilo_rst` stay Low for the whole run. The run goes from hold straight to the PMA hold, with no lock check.
- R7: Mode and both select vectors are sampled on every rising edge in the hold state, including the edge that leaves hold. The last sampled values set the outputs of the run. A `pma_rst` or `pcs_rst` bit whose select bit is Low is never High.
- R8: `rst_done` is High only in the done state, and all stage resets are Low there. It goes Low immediately, without a clock edge, when `rst_req` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_req | input | 1 | Asynchronous reset request, active High; its falling edge starts a run |
| seq_mode | input | 1 | 1: full bring-up, 0: component reset |
| pma_sel | input | PMA_W | PMA sub-block select bits |
| pcs_sel | input | PCS_W | PCS sub-block select bits |
| pll_lock | input | 1 | Clock-source PLL lock status |
| ilo_lock | input | 1 | Oscillator lock status |
| user_rdy | input | 1 | User logic ready, gates the PCS release |
| pll_rst | output | 1 | PLL reset |
| ilo_rst | output | 1 | Oscillator reset |
| pma_rst | output | PMA_W | Per-sub-block PMA resets |
| pcs_rst | output | PCS_W | Per-sub-block PCS resets |
| rst_done | output | 1 | Sequence complete |

## Verification
Every stage output is decoded from the state register, so it changes on the rising edge that follows the edge at which the deciding lock or ready input was sampled. The one exception is the start of a run, which lags the release of `rst_req` by three edges. `rst_done` and the hold outputs instead react to a rising `rst_req` with no clock at all. The bench changes its inputs one time unit after a falling edge and steps its behavioural model on each rising edge. It compares every output at the next falling edge, which lands each check in the cycle where the result is due. The asynchronous clear of `rst_done` is checked one time unit after the request rises, before any clock edge arrives.

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq #(
  parameter int PMA_W     = 4,
  parameter int PCS_W     = 4,
  parameter int PULSE_CYC = 4,
  parameter int PMA_CYC   = 16,
  parameter int LOCK_TMO  = 1024
)(
  input  logic             clk,
  input  logic             rst_req,
  input  logic             seq_mode,
  input  logic [PMA_W-1:0] pma_sel,
  input  logic [PCS_W-1:0] pcs_sel,
  input  logic             pll_lock,
  input  logic             ilo_lock,
  input  logic             user_rdy,
  output logic             pll_rst,
  output logic             ilo_rst,
  output logic [PMA_W-1:0] pma_rst,
  output logic [PCS_W-1:0] pcs_rst,
  output logic             rst_done
);
  localparam int MAX_A = (PULSE_CYC > PMA_CYC) ? PULSE_CYC : PMA_CYC;
  localparam int MAX_C = (MAX_A > LOCK_TMO) ? MAX_A : LOCK_TMO;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] PMA_END   = CNT_W'(PMA_CYC - 1);
  localparam logic [CNT_W-1:0] LOCK_END  = CNT_W'(LOCK_TMO - 1);

  typedef enum logic [2:0] {
    ST_HOLD, ST_PLL, ST_PLLW, ST_ILOW, ST_PMA, ST_USRW, ST_DONE
  } st_t;

  st_t              st, nxt;
  logic [CNT_W-1:0] cnt, lim;
  logic [2:0]       sync_q;
  logic             mode_r;
  logic [PMA_W-1:0] pma_m;
  logic [PCS_W-1:0] pcs_m;
  logic             start, timed, at_end;

  always_ff @(posedge clk or posedge rst_req)
    if (rst_req) sync_q <= 3'b111;
    else         sync_q <= {sync_q[1:0], 1'b0};

  assign start = sync_q[2] & ~sync_q[1];

  always_ff @(posedge clk)
    if (st == ST_HOLD) begin
      mode_r <= seq_mode;
      pma_m  <= pma_sel;
      pcs_m  <= pcs_sel;
    end

  always_comb begin
    lim = LOCK_END;
    case (st)
      ST_PLL:  lim = PULSE_END;
      ST_PMA:  lim = PMA_END;
      default: ;
    endcase
  end

  assign timed  = (st inside {ST_PLL, ST_PLLW, ST_ILOW, ST_PMA});
  assign at_end = (cnt == lim);

  always_comb begin
    nxt = st;
    case (st)
      ST_HOLD: if (start) nxt = seq_mode ? ST_PLL : ST_PMA;
      ST_PLL:  if (at_end) nxt = ST_PLLW;
      ST_PLLW: if (pll_lock) nxt = ST_ILOW;
               else if (at_end) nxt = ST_PLL;
      ST_ILOW: if (pll_lock && ilo_lock) nxt = ST_PMA;
               else if (at_end) nxt = ST_PLL;
      ST_PMA:  if (at_end) nxt = ST_USRW;
      ST_USRW: if (user_rdy) nxt = ST_DONE;
      default: ;
    endcase
  end

  always_ff @(posedge clk or posedge rst_req)
    if (rst_req) begin
      st  <= ST_HOLD;
      cnt <= '0;
    end else begin
      st  <= nxt;
      cnt <= (nxt != st || !timed) ? '0 : cnt + 1'b1;
    end

  assign pll_rst  = mode_r & (st == ST_HOLD || st == ST_PLL);
  assign ilo_rst  = mode_r & (st == ST_HOLD || st == ST_PLL || st == ST_PLLW);
  assign pma_rst  = (st inside {ST_HOLD, ST_PLL, ST_PLLW, ST_ILOW, ST_PMA}) ? pma_m : '0;
  assign pcs_rst  = (st != ST_DONE) ? pcs_m : '0;
  assign rst_done = (st == ST_DONE);

  AST_ILO_AFTER_PLL: assert property (@(posedge clk) disable iff (rst_req)
    $fell(ilo_rst) && st != ST_HOLD && $past(st) != ST_HOLD |-> $past(pll_lock)); // R2

  AST_PMA_AFTER_LOCKS: assert property (@(posedge clk) disable iff (rst_req)
    st == ST_PMA && $past(st) == ST_ILOW |-> $past(pll_lock && ilo_lock)); // R3

  AST_PCS_AFTER_USER: assert property (@(posedge clk) disable iff (rst_req)
    st == ST_DONE && $past(st) != ST_DONE |-> $past(user_rdy) && $past(pma_rst) == '0); // R4

  AST_TMO_RESTART: assert property (@(posedge clk) disable iff (rst_req)
    st == ST_PLL && $past(st) != ST_PLL && $past(st) != ST_HOLD |-> $past(cnt) == LOCK_END); // R5

  AST_COMP_NO_PLL: assert property (@(posedge clk) disable iff (rst_req)
    st != ST_HOLD && !mode_r |-> !pll_rst && !ilo_rst); // R6

  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst_req)
    rst_done |-> !pll_rst && !ilo_rst && pma_rst == '0 && pcs_rst == '0); // R8
endmodule

// File: tb/xcvr_rst_seq_bench.sv
module xcvr_rst_seq_bench;
  localparam int CLK_P = 10;
  localparam int PW = 4, CW = 4, PULSE = 3, PMAC = 5, TMO = 12;
  localparam int M_HOLD = 0, M_PLL = 1, M_PLLW = 2, M_ILOW = 3, M_PMA = 4, M_USRW = 5, M_DONE = 6;

  logic clk = 0;
  logic rst_req = 0, seq_mode = 1, pll_lock = 0, ilo_lock = 0, user_rdy = 0;
  logic [PW-1:0] pma_sel = '1;
  logic [CW-1:0] pcs_sel = '1;
  logic pll_rst, ilo_rst, rst_done;
  logic [PW-1:0] pma_rst;
  logic [CW-1:0] pcs_rst;

  int n_chk = 0, n_fail = 0;
  bit chk_on = 0;
  string cur_tag = "R1";

  int ph = M_HOLD, mc = 0;
  bit q1 = 1, q2 = 1, q3 = 1, m_mode = 1;
  logic [PW-1:0] m_pma = '1;
  logic [CW-1:0] m_pcs = '1;

  always #(CLK_P/2) clk = ~clk;

  xcvr_rst_seq #(.PMA_W(PW), .PCS_W(CW), .PULSE_CYC(PULSE), .PMA_CYC(PMAC), .LOCK_TMO(TMO)) u_xcvr_rst_seq (
    .clk(clk), .rst_req(rst_req), .seq_mode(seq_mode), .pma_sel(pma_sel), .pcs_sel(pcs_sel),
    .pll_lock(pll_lock), .ilo_lock(ilo_lock), .user_rdy(user_rdy),
    .pll_rst(pll_rst), .ilo_rst(ilo_rst), .pma_rst(pma_rst), .pcs_rst(pcs_rst), .rst_done(rst_done));

  task automatic cmp(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(posedge rst_req) begin
    ph = M_HOLD; mc = 0; q1 = 1; q2 = 1; q3 = 1;
  end

  always @(posedge clk) begin
    int np;
    bit start;
    np = ph;
    start = q3 && !q2;
    if (ph == M_HOLD) begin
      m_mode = seq_mode; m_pma = pma_sel; m_pcs = pcs_sel;
    end
    if (rst_req) begin
      np = M_HOLD; q1 = 1; q2 = 1; q3 = 1;
    end else begin
      case (ph)
        M_HOLD: if (start) np = seq_mode ? M_PLL : M_PMA;
        M_PLL:  if (mc == PULSE-1) np = M_PLLW;
        M_PLLW: if (pll_lock) np = M_ILOW; else if (mc == TMO-1) np = M_PLL;
        M_ILOW: if (pll_lock && ilo_lock) np = M_PMA; else if (mc == TMO-1) np = M_PLL;
        M_PMA:  if (mc == PMAC-1) np = M_USRW;
        M_USRW: if (user_rdy) np = M_DONE;
        default: ;
      endcase
      q3 = q2; q2 = q1; q1 = 0;
    end
    mc = (np != ph) ? 0 : mc + 1;
    ph = np;
  end

  always @(negedge clk) if (chk_on) begin
    bit pre_pma;
    pre_pma = (ph <= M_PMA);
    cmp(cur_tag, "pll_rst", pll_rst, m_mode && (ph == M_HOLD || ph == M_PLL));
    cmp(cur_tag, "ilo_rst", ilo_rst, m_mode && (ph <= M_PLLW));
    cmp(cur_tag, "pma_rst", pma_rst, pre_pma ? m_pma : '0);
    cmp(cur_tag, "pcs_rst", pcs_rst, (ph != M_DONE) ? m_pcs : '0);
    cmp(cur_tag, "rst_done", rst_done, ph == M_DONE);
  end

  task automatic wc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #1 rst_req = 1;
    @(posedge clk); chk_on = 1;
    cur_tag = "R1"; wc(4);
    rst_req = 0;
    wc(6);
    cur_tag = "R2"; wc(5); pll_lock = 1;
    cur_tag = "R3"; wc(3); ilo_lock = 1;
    wc(PMAC + 3);
    cur_tag = "R4"; user_rdy = 1;
    wc(5);
    cur_tag = "R8";
    rst_req = 1; #1;
    cmp("R8", "rst_done_async", rst_done, 0);
    cmp("R8", "pll_rst_async", pll_rst, 1);
    pll_lock = 0; ilo_lock = 0; user_rdy = 0;
    wc(3); rst_req = 0;
    cur_tag = "R5"; wc(3 * TMO + 10);
    pll_lock = 1; wc(TMO + 6);
    ilo_lock = 1; user_rdy = 1; wc(PMAC + 4);
    cur_tag = "R1";
    user_rdy = 0; pll_lock = 0; ilo_lock = 0;
    rst_req = 1; #2 rst_req = 0;
    wc(PULSE + 4);
    pll_lock = 1; ilo_lock = 1; wc(PMAC + 5);
    user_rdy = 1; wc(3);
    cur_tag = "R7";
    user_rdy = 0; pll_lock = 0; ilo_lock = 0;
    rst_req = 1; seq_mode = 1; pma_sel = 4'b0011; wc(1);
    pcs_sel = 4'b1100; wc(1);
    rst_req = 0; seq_mode = 0; pma_sel = 4'b1010; wc(1);
    pcs_sel = 4'b0110;
    cur_tag = "R6"; wc(PMAC + 6);
    user_rdy = 1; wc(4);
    summary();
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    summary();
    $finish;
  end
endmodule